// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave with Address Counter

This block is a two-wire bus slave that fronts a 512-byte memory held in a synthesizable register array. It oversamples the bus clock and data lines with the system clock, detects start and stop conditions, and drives an active-high pull-down enable for the open-drain data line. After every start it decodes a slave address byte and checks the byte's type code and its two select bits. The select bits are compared with two strap inputs. A 9-bit address counter holds the memory address. Its top bit comes from the slave address byte and its low byte comes from the byte that follows on the bus.

A master runs a random read as a write-mode slave address, an address byte, a repeated start and a read-mode slave address. If the master sends a stop after the address byte, the counter is loaded and the slave goes idle. The next current-address read then returns data from that address. Reads continue byte after byte while the master acknowledges, and the counter wraps from the last address to 0. Single-byte writes exist so that the memory can be loaded.

States: `ST_IDLE` ignores the bus until a start. `ST_DEV` shifts in the slave address byte. `ST_DEV_ACK` acknowledges it. `ST_WADDR` and `ST_WADDR_ACK` take the low address byte. `ST_WDATA` and `ST_WDATA_ACK` receive and store write data. `ST_RDATA` shifts out a byte. `ST_RDATA_ACK` samples the master's acknowledge. The transitions are:
- A stop goes to `ST_IDLE` and a start goes to `ST_DEV` from any state.
- `ST_DEV` goes to `ST_DEV_ACK` on a match, or to `ST_IDLE` if the byte does not match.
- `ST_DEV_ACK` goes to `ST_RDATA` for a read or to `ST_WADDR` for a write.
- `ST_WADDR` goes to `ST_WADDR_ACK`, then to `ST_WDATA`.
- `ST_WDATA` goes to `ST_WDATA_ACK`, then back to `ST_WDATA`.
- `ST_RDATA` goes to `ST_RDATA_ACK`.
- `ST_RDATA_ACK` goes to `ST_RDATA` on an acknowledge or to `ST_IDLE` on a not-acknowledge.

Top module: `eeprom_twi_slave`

## Requirements
- R1: The slave address byte carries the type code in bits [7:4], which must be 1010b. Any other code gets no acknowledge, and the rest of the transfer up to the next start is ignored. No write is made.
- R2: Bits [3:2] of the slave address byte must equal the `dev_sel` strap inputs (bit 3 against `dev_sel[1]`). The slave acknowledges only on a match.
- R3: Bit [1] of a write-mode slave address byte becomes address bit 8, and the next byte supplies address bits [7:0]. All bytes are sent MSB first. Bit [1] of a read-mode slave address byte does not change the counter.
- R4: Bit [0] of the slave address byte selects the direction: 1 is a read and 0 is a write.
- R5: A random read returns the byte at the address that the dummy write loaded, followed by a repeated start and a read-mode slave address.
- R6: A stop after the address byte loads the counter only. The next current-address read returns the byte at that address.
- R7: After a stop, bus activity without a start is neither acknowledged nor acted on. A start or stop in the middle of a byte abandons that byte and leaves the counter and memory unchanged.
- R8: Each byte read advances the counter by one, and 511 is followed by 0. A sequential read continues while the master acknowledges.
- R9: After the master's not-acknowledge, and while idle, the slave releases the data line. The data-line enable changes only while the bus clock is low.
- R10: In a write, each data byte is acknowledged and stored at the counter address. The counter then advances with the same wrap to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level (wired-AND of all drivers) |
| dev_sel | input | 2 | Device select straps compared with address byte bits [3:2] |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
A wrong state in the machine shows up on `sda_oe` within the next bus bit. The symptoms are a missing or extra acknowledge, a data bit driven where the line should be released, or the line held low through the master's acknowledge slot. A wrong address counter does not show until a later read returns the wrong byte. For that reason the counter is checked through set-address followed by current reads, through a wrap across 511, and after transfers that were abandoned in the middle of a byte.

// File: rtl/eeprom_twi_pkg.sv
package eeprom_twi_pkg;

    localparam logic [3:0] DEV_TYPE_CODE = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK
    } twi_state_e;

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_q;
    logic                   sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_in};
            scl_q    <= scl_pipe[SYNC_STAGES-1];
            sda_q    <= sda_pipe[SYNC_STAGES-1];
        end
    end

    assign scl_lvl   = scl_pipe[SYNC_STAGES-1];
    assign sda_lvl   = sda_pipe[SYNC_STAGES-1];
    assign scl_rise  = scl_lvl & ~scl_q;
    assign scl_fall  = ~scl_lvl & scl_q;
    assign start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;

endmodule

// File: rtl/twi_mem.sv
module twi_mem #(
    parameter int DEPTH = 512,
    parameter int WIDTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/eeprom_twi_slave.sv
module eeprom_twi_slave #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic [1:0] dev_sel,
    output logic       sda_oe
);
    import eeprom_twi_pkg::*;

    localparam int MEM_BYTES = 512;
    localparam int ADDR_W    = $clog2(MEM_BYTES);
    localparam logic [3:0] BYTE_DONE = 4'd8;

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

    twi_line_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    twi_state_e        state, state_n;
    logic [3:0]        bitcnt;
    logic [7:0]        rx_sr;
    logic [7:0]        tx_sr;
    logic [ADDR_W-1:0] addr;
    logic              hi_bit;
    logic              master_ack;
    logic              mem_we;
    logic [7:0]        mem_rdata;
    logic              dev_match;
    logic              byte_end;

    twi_mem #(.DEPTH(MEM_BYTES), .WIDTH(8)) i_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (addr),
        .wdata (rx_sr),
        .raddr (addr),
        .rdata (mem_rdata)
    );

    assign dev_match = (rx_sr[7:4] == DEV_TYPE_CODE) && (rx_sr[3:2] == dev_sel);
    assign byte_end  = scl_fall && (bitcnt == BYTE_DONE);

    // next-state logic
    always_comb begin
        state_n = state;
        if (stop_det) begin
            state_n = ST_IDLE;
        end else if (start_det) begin
            state_n = ST_DEV;
        end else begin
            unique case (state)
                ST_IDLE:      state_n = ST_IDLE;
                ST_DEV:       if (byte_end) state_n = dev_match ? ST_DEV_ACK : ST_IDLE;
                ST_DEV_ACK:   if (scl_fall) state_n = rx_sr[0] ? ST_RDATA : ST_WADDR;
                ST_WADDR:     if (byte_end) state_n = ST_WADDR_ACK;
                ST_WADDR_ACK: if (scl_fall) state_n = ST_WDATA;
                ST_WDATA:     if (byte_end) state_n = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) state_n = ST_WDATA;
                ST_RDATA:     if (byte_end) state_n = ST_RDATA_ACK;
                ST_RDATA_ACK: if (scl_fall) state_n = master_ack ? ST_RDATA : ST_IDLE;
                default:      state_n = ST_IDLE;
            endcase
        end
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            bitcnt     <= '0;
            rx_sr      <= '0;
            tx_sr      <= '0;
            addr       <= '0;
            hi_bit     <= 1'b0;
            master_ack <= 1'b0;
        end else begin
            state <= state_n;
            if (start_det || stop_det) begin
                bitcnt <= '0;
            end else if (scl_rise) begin
                unique case (state)
                    ST_DEV, ST_WADDR, ST_WDATA: begin
                        rx_sr <= {rx_sr[6:0], sda_lvl};
                        if (bitcnt != BYTE_DONE) bitcnt <= bitcnt + 4'd1;
                    end
                    ST_RDATA: begin
                        if (bitcnt != BYTE_DONE) bitcnt <= bitcnt + 4'd1;
                    end
                    ST_RDATA_ACK: master_ack <= ~sda_lvl;
                    default: ;
                endcase
            end else if (scl_fall) begin
                unique case (state)
                    ST_DEV: begin
                        if (bitcnt == BYTE_DONE) hi_bit <= rx_sr[1];
                    end
                    ST_DEV_ACK: begin
                        bitcnt <= '0;
                        tx_sr  <= mem_rdata;
                    end
                    ST_WADDR: begin
                        if (bitcnt == BYTE_DONE) addr <= {hi_bit, rx_sr};
                    end
                    ST_WADDR_ACK, ST_WDATA_ACK: bitcnt <= '0;
                    ST_WDATA: begin
                        if (bitcnt == BYTE_DONE) addr <= addr + 1'b1;
                    end
                    ST_RDATA: begin
                        if (bitcnt == BYTE_DONE) addr <= addr + 1'b1;
                        else                     tx_sr <= {tx_sr[6:0], 1'b0};
                    end
                    ST_RDATA_ACK: begin
                        bitcnt <= '0;
                        tx_sr  <= mem_rdata;
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        mem_we = (state == ST_WDATA) && byte_end && !start_det && !stop_det;
        unique case (state)
            ST_DEV_ACK, ST_WADDR_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_RDATA:                               sda_oe = ~tx_sr[7];
            default:                                sda_oe = 1'b0;
        endcase
    end

    // R2: acknowledge of the address byte only with the right type and select bits
    p_ack_needs_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEV_ACK) |-> (rx_sr[7:4] == DEV_TYPE_CODE && rx_sr[3:2] == dev_sel));

    // R8: each byte sent moves the counter forward by one, wrapping at 511
    p_read_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RDATA_ACK && $past(state) == ST_RDATA) |-> (addr == $past(addr) + 1'b1));

    // R7: a stop always returns the slave to idle with the line released
    p_stop_idles_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE && !sda_oe));

    // R7: a start always returns the slave to address decoding
    p_start_decodes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_det) |=> (state == ST_DEV));

    // R9: the data-line enable moves only while the bus clock is low
    p_sda_moves_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_lvl);

endmodule

// File: tb/test_eeprom_twi_slave.sv
`timescale 1ns/1ps
module test_eeprom_twi_slave;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] sel = 2'b01;
    logic       sda_oe;
    logic       sda_line;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    eeprom_twi_slave i_eeprom_twi_slave (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_in  (scl),
        .sda_in  (sda_line),
        .dev_sel (sel),
        .sda_oe  (sda_oe)
    );

    task automatic w(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] dev(input logic rw, input logic a8, input logic [1:0] s);
        return {4'b1010, s, a8, rw};
    endfunction

    task automatic bus_start();
        scl = 1'b0; w(6); sda_m = 1'b1; w(6); scl = 1'b1; w(6); sda_m = 1'b0; w(6);
    endtask

    task automatic bus_stop();
        scl = 1'b0; w(6); sda_m = 1'b0; w(6); scl = 1'b1; w(6); sda_m = 1'b1; w(6);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            scl = 1'b0; w(6); sda_m = b[i]; w(6); scl = 1'b1; w(12);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        send_bits(b, 8);
        scl = 1'b0; w(6); sda_m = 1'b1; w(6); scl = 1'b1; w(6);
        acked = !sda_line;
        w(6);
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] d, output bit released);
        for (int i = 7; i >= 0; i--) begin
            scl = 1'b0; w(6); sda_m = 1'b1; w(6); scl = 1'b1; w(6);
            d[i] = sda_line;
            w(6);
        end
        scl = 1'b0; w(6); sda_m = mack ? 1'b0 : 1'b1; w(6); scl = 1'b1; w(6);
        released = (sda_line == sda_m);
        w(6);
    endtask

    task automatic wr_byte(input logic [8:0] a, input logic [7:0] d);
        bit ak;
        bus_start();
        send_byte(dev(1'b0, a[8], sel), ak); chk(ak, "R4 write address ack", ak, 1);
        send_byte(a[7:0], ak);               chk(ak, "R3 word address ack", ak, 1);
        send_byte(d, ak);                    chk(ak, "R10 data ack", ak, 1);
        bus_stop();
    endtask

    task automatic set_addr(input logic [8:0] a);
        bit ak;
        bus_start();
        send_byte(dev(1'b0, a[8], sel), ak);
        send_byte(a[7:0], ak);
        bus_stop();
    endtask

    task automatic cur_read(input logic a8, output logic [7:0] d);
        bit ak, rel;
        bus_start();
        send_byte(dev(1'b1, a8, sel), ak); chk(ak, "R4 read address ack", ak, 1);
        recv_byte(1'b0, d, rel);           chk(rel, "R9 released at nack", rel, 1);
        bus_stop();
    endtask

    task automatic t_reset();
        chk(sda_line == 1'b1, "R9 released after reset", sda_line, 1);
    endtask

    task automatic t_write_wrap();
        bit ak;
        bus_start();
        send_byte(dev(1'b0, 1'b1, sel), ak); chk(ak, "R2 matching select ack", ak, 1);
        send_byte(8'hFE, ak);
        send_byte(8'hAA, ak); chk(ak, "R10 ack at 1FE", ak, 1);
        send_byte(8'hBB, ak); chk(ak, "R10 ack at 1FF", ak, 1);
        send_byte(8'hCC, ak); chk(ak, "R10 ack at 000 after wrap", ak, 1);
        bus_stop();
        wr_byte(9'h005, 8'h55);
        wr_byte(9'h105, 8'h66);
    endtask

    task automatic rand_read(input logic [8:0] a, output logic [7:0] d);
        bit ak, rel;
        bus_start();
        send_byte(dev(1'b0, a[8], sel), ak);
        send_byte(a[7:0], ak);
        bus_start();
        send_byte(dev(1'b1, 1'b0, sel), ak); chk(ak, "R5 read after restart ack", ak, 1);
        recv_byte(1'b0, d, rel);
        bus_stop();
    endtask

    task automatic t_random();
        logic [7:0] d;
        rand_read(9'h105, d); chk(d == 8'h66, "R5 R3 random read 105", d, 8'h66);
        rand_read(9'h005, d); chk(d == 8'h55, "R5 R3 random read 005", d, 8'h55);
        rand_read(9'h000, d); chk(d == 8'hCC, "R10 wrapped write at 000", d, 8'hCC);
    endtask

    task automatic t_set_addr();
        logic [7:0] d;
        set_addr(9'h1FE);
        cur_read(1'b0, d); chk(d == 8'hAA, "R6 current read after set", d, 8'hAA);
        cur_read(1'b0, d); chk(d == 8'hBB, "R8 counter advanced", d, 8'hBB);
        set_addr(9'h005);
        cur_read(1'b1, d); chk(d == 8'h55, "R3 read-mode a8 ignored", d, 8'h55);
    endtask

    task automatic t_seq_wrap();
        logic [7:0] d;
        bit ak, rel;
        set_addr(9'h1FE);
        bus_start();
        send_byte(dev(1'b1, 1'b0, sel), ak);
        recv_byte(1'b1, d, rel); chk(d == 8'hAA, "R8 sequential byte 0", d, 8'hAA);
        recv_byte(1'b1, d, rel); chk(d == 8'hBB, "R8 sequential byte 1", d, 8'hBB);
        recv_byte(1'b0, d, rel); chk(d == 8'hCC, "R8 sequential wrap to 000", d, 8'hCC);
        chk(rel, "R9 released during nack", rel, 1);
        bus_stop();
        chk(sda_line == 1'b1, "R9 released after stop", sda_line, 1);
    endtask

    task automatic t_bad_type();
        bit ak;
        logic [7:0] d;
        bus_start();
        send_byte({4'b1011, sel, 1'b1, 1'b0}, ak); chk(!ak, "R1 wrong type no ack", ak, 0);
        send_byte(8'hFE, ak); chk(!ak, "R1 rest ignored", ak, 0);
        send_byte(8'h00, ak); chk(!ak, "R1 data ignored", ak, 0);
        bus_stop();
        rand_read(9'h1FE, d); chk(d == 8'hAA, "R1 memory unchanged", d, 8'hAA);
    endtask

    task automatic t_bad_sel();
        bit ak;
        bus_start();
        send_byte(dev(1'b1, 1'b0, ~sel), ak); chk(!ak, "R2 select mismatch no ack", ak, 0);
        bus_stop();
        sel = 2'b10;
        w(4);
        bus_start();
        send_byte(dev(1'b1, 1'b0, 2'b01), ak); chk(!ak, "R2 old select no ack", ak, 0);
        bus_stop();
        bus_start();
        send_byte(dev(1'b0, 1'b0, 2'b10), ak); chk(ak, "R2 new select ack", ak, 1);
        bus_stop();
        sel = 2'b01;
        w(4);
    endtask

    task automatic t_ignore_abort();
        bit ak, rel;
        logic [7:0] d;
        set_addr(9'h005);
        send_byte(dev(1'b1, 1'b0, sel), ak); chk(!ak, "R7 no start no ack", ak, 0);
        bus_stop();
        bus_start();
        send_byte(dev(1'b0, 1'b1, sel), ak);
        send_bits(8'hFE, 4);
        bus_stop();
        cur_read(1'b0, d); chk(d == 8'h55, "R7 mid-byte stop keeps counter", d, 8'h55);
        set_addr(9'h105);
        bus_start();
        send_byte(dev(1'b0, 1'b0, sel), ak);
        send_bits(8'h00, 3);
        bus_start();
        send_byte(dev(1'b1, 1'b0, sel), ak); chk(ak, "R7 mid-byte start decodes", ak, 1);
        recv_byte(1'b0, d, rel); chk(d == 8'h66, "R7 mid-byte start keeps counter", d, 8'h66);
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        w(5);
        rst_n = 1'b1;
        w(5);
        t_reset();
        t_write_wrap();
        t_random();
        t_set_addr();
        t_seq_wrap();
        t_bad_type();
        t_bad_sel();
        t_ignore_abort();
        w(10);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule